// File: doc/BRIEF.md
# RISC-V Subset Control Decoder

This block is the purely combinational control path of a small single-cycle RV32I-subset core. It takes the fields of the instruction now being executed (the 7-bit opcode, funct3 and bit 5 of funct7) together with the ALU zero flag. From these it produces every steering strobe the datapath needs for that cycle: register write enable, data memory write enable, the ALU second-operand select, the immediate format, the write-back source, the next-PC select and the ALU function code.

Decoding happens in two levels. The first level turns the opcode into a strobe bundle that includes a 2-bit ALU operation class. The second level combines that class with funct3 and funct7 bit 5 to choose the ALU function. Six instruction classes are recognised: register-register arithmetic, add-immediate, word load, word store, branch-if-equal and jump-and-link. The only branch condition is equality, and it is read from the ALU zero flag while the ALU subtracts the two operands.

Top module: `rv_subset_ctrl`

Encodings used on the outputs:
- immSrc: 00 = I-type, 01 = S-type, 10 = B-type, 11 = J-type.
- resultSrc: 00 = ALU result, 01 = memory read data, 10 = PC+4.
- aluCtl: 000 = add, 001 = subtract, 010 = and, 011 = or, 101 = set-less-than.

## Requirements
- R1: For opcode 0110011 (register-register) the outputs are regWrite=1, memWrite=0, aluSrc=0 (register operand), resultSrc=00 and pcSrc=0.
- R2: For opcode 0010011 (add-immediate) the outputs are regWrite=1, memWrite=0, aluSrc=1, immSrc=00, resultSrc=00 and pcSrc=0. With funct3=000 the result is aluCtl=000 (add) for either value of funct7 bit 5.
- R3: For opcode 0000011 (load word) the outputs are regWrite=1, memWrite=0, aluSrc=1, immSrc=00, resultSrc=01, aluCtl=000 and pcSrc=0, whatever funct3 and funct7 bit 5 hold.
- R4: For opcode 0100011 (store word) the outputs are memWrite=1, regWrite=0, aluSrc=1, immSrc=01, aluCtl=000 and pcSrc=0, whatever funct3 and funct7 bit 5 hold.
- R5: For opcode 1100011 (branch-if-equal) the outputs are regWrite=0, memWrite=0, aluSrc=0, immSrc=10 and aluCtl=001 (subtract). pcSrc equals the zero input.
- R6: For opcode 1101111 (jump-and-link) the outputs are regWrite=1, memWrite=0, immSrc=11, resultSrc=10 and pcSrc=1 regardless of zero.
- R7: For opcodes 0110011 and 0010011 the ALU code follows funct3 as follows. 111 gives and (010), 110 gives or (011) and 010 gives set-less-than (101). 000 gives subtract (001) only when the opcode is 0110011 and funct7 bit 5 is 1, and add (000) otherwise. Every other funct3 value gives add (000).
- R8: For any other opcode, regWrite=0, memWrite=0 and pcSrc=0, so no architectural state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Instruction bits 6:0 |
| funct3 | input | 3 | Instruction bits 14:12 |
| funct7b5 | input | 1 | Instruction bit 30 |
| zero | input | 1 | ALU result-is-zero flag |
| pcSrc | output | 1 | 1 = next PC is the PC-relative target, 0 = PC+4 |
| regWrite | output | 1 | Register file write enable |
| memWrite | output | 1 | Data memory write enable |
| aluSrc | output | 1 | 1 = ALU operand B is the immediate |
| immSrc | output | 2 | Immediate format select |
| resultSrc | output | 2 | Write-back source select |
| aluCtl | output | 3 | ALU function code |

## Verification
The case that is hardest to reach is the one where the fields interact: funct7 bit 5 set together with funct3=000. That input must turn into a subtract for register-register instructions and must be ignored for add-immediate, and a randomly chosen operation that uses funct7 bit 5 only rarely lands on it. The stimulus therefore sweeps every opcode against every funct3, both funct7 bit 5 values and both zero values (4096 combinations). Each output is compared with a model written from the requirement tables, so the add-immediate case with bit 30 set and the not-taken branch are both covered by construction.

// File: rtl/rv_ctrl_pkg.sv
package rv_ctrl_pkg;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int ALUC_W  = 3;
  localparam int CLASS_W = 2;
  localparam int SEL_W   = 2;

  localparam logic [OPC_W-1:0] OPC_REG   = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL   = 7'b1101111;

  typedef enum logic [SEL_W-1:0] {
    IMM_I = 2'b00, IMM_S = 2'b01, IMM_B = 2'b10, IMM_J = 2'b11
  } immFmt_e;

  typedef enum logic [SEL_W-1:0] {
    RES_ALU = 2'b00, RES_MEM = 2'b01, RES_PC4 = 2'b10
  } resSel_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_ADD = 2'b00, CLS_SUB = 2'b01, CLS_FUNCT = 2'b10
  } aluClass_e;

  typedef enum logic [ALUC_W-1:0] {
    ALU_ADD = 3'b000, ALU_SUB = 3'b001, ALU_AND = 3'b010,
    ALU_OR  = 3'b011, ALU_SLT = 3'b101
  } aluFn_e;

  typedef struct packed {
    logic      regWrite;
    logic      memWrite;
    logic      aluSrcImm;
    logic      branch;
    logic      jump;
    immFmt_e   immSel;
    resSel_e   resultSel;
    aluClass_e aluClass;
  } ctrlStrobes_t;
endpackage

// File: rtl/rv_main_dec.sv
module rv_main_dec
  import rv_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrobes_t     strobes
);
  always_comb begin
    strobes = '{regWrite: 1'b0, memWrite: 1'b0, aluSrcImm: 1'b0,
                branch: 1'b0, jump: 1'b0, immSel: IMM_I,
                resultSel: RES_ALU, aluClass: CLS_ADD};
    case (opcode)
      OPC_REG: begin
        strobes.regWrite = 1'b1;
        strobes.aluClass = CLS_FUNCT;
      end
      OPC_ADDI: begin
        strobes.regWrite  = 1'b1;
        strobes.aluSrcImm = 1'b1;
        strobes.aluClass  = CLS_FUNCT;
      end
      OPC_LOAD: begin
        strobes.regWrite  = 1'b1;
        strobes.aluSrcImm = 1'b1;
        strobes.resultSel = RES_MEM;
      end
      OPC_STORE: begin
        strobes.memWrite  = 1'b1;
        strobes.aluSrcImm = 1'b1;
        strobes.immSel    = IMM_S;
      end
      OPC_BEQ: begin
        strobes.branch   = 1'b1;
        strobes.immSel   = IMM_B;
        strobes.aluClass = CLS_SUB;
      end
      OPC_JAL: begin
        strobes.regWrite  = 1'b1;
        strobes.jump      = 1'b1;
        strobes.immSel    = IMM_J;
        strobes.resultSel = RES_PC4;
      end
      default: ;
    endcase
  end

  always_comb begin
    AST_STORE_NO_WRITEBACK: assert (!(strobes.memWrite && strobes.regWrite))
      else $error("store also writes the register file"); // R4
    AST_BRANCH_NOT_JUMP: assert (!(strobes.branch && strobes.jump))
      else $error("branch and jump both raised"); // R5
  end
endmodule

// File: rtl/rv_alu_dec.sv
module rv_alu_dec
  import rv_ctrl_pkg::*;
(
  input  aluClass_e       aluClass,
  input  logic [F3_W-1:0] funct3,
  input  logic            funct7b5,
  input  logic            opIsReg,
  output aluFn_e          aluFn
);
  logic subSelect;
  assign subSelect = opIsReg && funct7b5;

  always_comb begin
    case (aluClass)
      CLS_SUB:   aluFn = ALU_SUB;
      CLS_FUNCT: begin
        case (funct3)
          3'b000:  aluFn = subSelect ? ALU_SUB : ALU_ADD;
          3'b111:  aluFn = ALU_AND;
          3'b110:  aluFn = ALU_OR;
          3'b010:  aluFn = ALU_SLT;
          default: aluFn = ALU_ADD;
        endcase
      end
      default:   aluFn = ALU_ADD;
    endcase
  end

  always_comb begin
    AST_SUB_NEEDS_REASON: assert (!(aluFn == ALU_SUB && aluClass == CLS_ADD))
      else $error("subtract chosen for an address add"); // R7
  end
endmodule

// File: rtl/rv_subset_ctrl.sv
module rv_subset_ctrl
  import rv_ctrl_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic       funct7b5,
  input  logic       zero,
  output logic       pcSrc,
  output logic       regWrite,
  output logic       memWrite,
  output logic       aluSrc,
  output logic [1:0] immSrc,
  output logic [1:0] resultSrc,
  output logic [2:0] aluCtl
);
  ctrlStrobes_t strobes;
  aluFn_e       aluFn;

  rv_main_dec mainDec (
    .opcode (opcode),
    .strobes(strobes)
  );

  rv_alu_dec aluDec (
    .aluClass(strobes.aluClass),
    .funct3  (funct3),
    .funct7b5(funct7b5),
    .opIsReg (opcode[5]),
    .aluFn   (aluFn)
  );

  assign pcSrc     = (strobes.branch && zero) || strobes.jump;
  assign regWrite  = strobes.regWrite;
  assign memWrite  = strobes.memWrite;
  assign aluSrc    = strobes.aluSrcImm;
  assign immSrc    = strobes.immSel;
  assign resultSrc = strobes.resultSel;
  assign aluCtl    = aluFn;

  always_comb begin
    AST_LOAD_ADDS: assert (!(resultSrc == RES_MEM && aluCtl != ALU_ADD))
      else $error("load address not formed by add"); // R3
    AST_STORE_IMM: assert (!(memWrite && !aluSrc))
      else $error("store without immediate operand"); // R4
    AST_BRANCH_NEEDS_ZERO: assert (!(strobes.branch && !zero && pcSrc))
      else $error("branch taken without zero"); // R5
    AST_JAL_LINKS: assert (!(strobes.jump && !(regWrite && resultSrc == RES_PC4)))
      else $error("jump does not write PC+4"); // R6
  end
endmodule

// File: tb/rv_subset_ctrl_test.sv
`timescale 1ns/1ps
module rv_subset_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [6:0] opcode = '0;
  logic [2:0] funct3 = '0;
  logic       funct7b5 = 1'b0;
  logic       zero = 1'b0;
  logic       pcSrc, regWrite, memWrite, aluSrc;
  logic [1:0] immSrc, resultSrc;
  logic [2:0] aluCtl;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  rv_subset_ctrl uut (
    .opcode(opcode), .funct3(funct3), .funct7b5(funct7b5), .zero(zero),
    .pcSrc(pcSrc), .regWrite(regWrite), .memWrite(memWrite), .aluSrc(aluSrc),
    .immSrc(immSrc), .resultSrc(resultSrc), .aluCtl(aluCtl)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s op=%b f3=%b f7=%b z=%b actual=%0d expected=%0d",
               tag, what, opcode, funct3, funct7b5, zero, act, exp);
    end
  endtask

  function automatic int expAlu(input logic [6:0] op, input logic [2:0] f3, input logic f7);
    case (f3)
      3'b111: return 2;
      3'b110: return 3;
      3'b010: return 5;
      3'b000: return (op == 7'b0110011 && f7) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic checkAll();
    case (opcode)
      7'b0110011: begin
        chk("R1", "regWrite", regWrite, 1); chk("R1", "memWrite", memWrite, 0);
        chk("R1", "aluSrc", aluSrc, 0); chk("R1", "resultSrc", resultSrc, 0);
        chk("R1", "pcSrc", pcSrc, 0);
        chk("R7", "aluCtl", aluCtl, expAlu(opcode, funct3, funct7b5));
      end
      7'b0010011: begin
        chk("R2", "regWrite", regWrite, 1); chk("R2", "memWrite", memWrite, 0);
        chk("R2", "aluSrc", aluSrc, 1); chk("R2", "immSrc", immSrc, 0);
        chk("R2", "resultSrc", resultSrc, 0); chk("R2", "pcSrc", pcSrc, 0);
        chk("R7", "aluCtl", aluCtl, expAlu(opcode, funct3, funct7b5));
      end
      7'b0000011: begin
        chk("R3", "regWrite", regWrite, 1); chk("R3", "memWrite", memWrite, 0);
        chk("R3", "aluSrc", aluSrc, 1); chk("R3", "immSrc", immSrc, 0);
        chk("R3", "resultSrc", resultSrc, 1); chk("R3", "aluCtl", aluCtl, 0);
        chk("R3", "pcSrc", pcSrc, 0);
      end
      7'b0100011: begin
        chk("R4", "memWrite", memWrite, 1); chk("R4", "regWrite", regWrite, 0);
        chk("R4", "aluSrc", aluSrc, 1); chk("R4", "immSrc", immSrc, 1);
        chk("R4", "aluCtl", aluCtl, 0); chk("R4", "pcSrc", pcSrc, 0);
      end
      7'b1100011: begin
        chk("R5", "regWrite", regWrite, 0); chk("R5", "memWrite", memWrite, 0);
        chk("R5", "aluSrc", aluSrc, 0); chk("R5", "immSrc", immSrc, 2);
        chk("R5", "aluCtl", aluCtl, 1); chk("R5", "pcSrc", pcSrc, int'(zero));
      end
      7'b1101111: begin
        chk("R6", "regWrite", regWrite, 1); chk("R6", "memWrite", memWrite, 0);
        chk("R6", "immSrc", immSrc, 3); chk("R6", "resultSrc", resultSrc, 2);
        chk("R6", "pcSrc", pcSrc, 1);
      end
      default: begin
        chk("R8", "regWrite", regWrite, 0); chk("R8", "memWrite", memWrite, 0);
        chk("R8", "pcSrc", pcSrc, 0);
      end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkAll();   // idle state: all-zero opcode is unlisted, R8
    rst = 1'b0;
    for (int op = 0; op < 128; op++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int f7 = 0; f7 < 2; f7++) begin
          for (int z = 0; z < 2; z++) begin
            @(posedge clk);
            #1;
            opcode = 7'(op); funct3 = 3'(f3); funct7b5 = f7[0]; zero = z[0];
            #1;
            checkAll();
          end
        end
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule